// File: doc/BRIEF.md
# Programmable PLL Lock Detector

This block decides when a frequency synthesizer's loop has settled. Once per reference period it counts the sampling-clock cycles in which the phase-frequency detector drives an up or down correction pulse. A period whose error count stays within a programmed tolerance is a good period. After a programmed number of consecutive good periods the block raises its lock flag.

A mode bit sets what happens after lock. In latch mode, lock stays up and no more periods are analysed. In re-check mode, analysis continues and a single bad period drops lock again. The lock flag drives two outputs. It reaches the lock-detect pin only when the part is in programmable mode. It also enables the power amplifier automatically, unless that automatic turn-on is disabled.

Any of three events clears lock, the good-period count and the error measurement: the synthesizer being switched off, a retune strobe (issued when the divider ratio or operating mode changes), or reset. The first reference tick after a clear only opens a measurement period; it does not judge one.

Top module: `pll_lock_detect`

## Requirements
- R1: The error of a period is the number of sampling cycles in which `pfd_up` or `pfd_dn` is high, counted from the cycle that carries `ref_tick` up to the cycle before the next `ref_tick`. The period is good when this count is at most the tolerance chosen by `tol_code`: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16.
- R2: `lock` rises at the clock edge that samples the `ref_tick` closing the N-th consecutive good evaluated period, where `qual_code` 0 gives N=4, 1 gives 16, 2 gives 64, 3 gives 256. It does not rise at any other edge.
- R3: With `recheck` at 0, periods are not analysed while `lock` is high, so bad periods leave `lock` at 1.
- R4: With `recheck` at 1, a bad period evaluated while locked clears `lock` and the good count, and N new good periods are needed to lock again.
- R5: A bad period evaluated before lock resets the good-period count to zero.
- R6: At the edge after a cycle with `synth_en` low or `retune` high, `lock`, the good count and the error count are cleared. The next `ref_tick` after a clear only opens a period; it is not evaluated.
- R7: `pa_en` equals `lock` while `pa_auto_off` is 0, and is 0 while `pa_auto_off` is 1.
- R8: `lock_pin` equals `lock` while `prog_mode` is 1, and is 0 while `prog_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| synth_en | input | 1 | Synthesizer enabled; low clears lock state |
| retune | input | 1 | One-cycle strobe on divider or mode change; clears lock state |
| prog_mode | input | 1 | Programmable mode; lets lock reach the pin |
| ref_tick | input | 1 | One-cycle marker at the start of each reference period |
| pfd_up | input | 1 | Detector up pulse |
| pfd_dn | input | 1 | Detector down pulse |
| tol_code | input | 2 | Error tolerance select |
| qual_code | input | 2 | Qualification count select |
| recheck | input | 1 | 0 latch lock, 1 keep analysing after lock |
| pa_auto_off | input | 1 | 1 disables automatic amplifier turn-on |
| lock | output | 1 | Lock flag |
| lock_pin | output | 1 | Lock flag gated by programmable mode |
| pa_en | output | 1 | Automatic power-amplifier enable |

## Verification
The assertions assume that `ref_tick` is a single-cycle strobe and that the programming fields stay steady while periods are being qualified. They also assume that retune is a single-cycle pulse. The bench drives every period as a tick cycle followed by a run of error cycles and then quiet cycles, with the periods always longer than the largest error window. It changes the codes only in the quiet cycles between scenarios, and it issues clears through `synth_en` or `retune` one cycle at a time.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
   // Acceptable error cycles per reference period for a tolerance code.
   function automatic int unsigned tol_cycles(input int unsigned base, input logic [1:0] code);
      return base << code;
   endfunction

   // Consecutive good periods needed for a qualification code.
   function automatic int unsigned qual_periods(input int unsigned log2_base,
                                                input int unsigned log2_step,
                                                input logic [1:0] code);
      return 32'd1 << (log2_base + log2_step * int'(code));
   endfunction
endpackage

// File: rtl/lkd_err_meter.sv
module lkd_err_meter #(
   parameter int unsigned ERR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             up,
   input  logic             dn,
   output logic [ERR_W-1:0] err,
   output logic             armed
);
   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   logic             hit;
   logic [ERR_W-1:0] err_q;
   logic             armed_q;

   assign hit = up | dn;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         err_q   <= '0;
         armed_q <= 1'b0;
      end else if (tick) begin
         err_q   <= {{(ERR_W-1){1'b0}}, hit};
         armed_q <= 1'b1;
      end else if (hit && err_q != ERR_MAX) begin
         err_q   <= err_q + 1'b1;
      end
   end

   assign err   = err_q;
   assign armed = armed_q;
endmodule

// File: rtl/lkd_qualifier.sv
module lkd_qualifier #(
   parameter int unsigned ERR_W      = 6,
   parameter int unsigned TOL_BASE   = 2,
   parameter int unsigned QUAL_LOG2  = 2,
   parameter int unsigned QUAL_STEP  = 2,
   localparam int unsigned CNT_W     = QUAL_LOG2 + 3 * QUAL_STEP + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             eval,
   input  logic [ERR_W-1:0] err,
   input  logic [1:0]       tol_code,
   input  logic [1:0]       qual_code,
   input  logic             recheck,
   output logic             lock
);
   logic [CNT_W-1:0] good_q;
   logic [CNT_W-1:0] need;
   logic [CNT_W:0]   good_inc;
   logic [ERR_W-1:0] tol;
   logic             lock_q;
   logic             analyse;
   logic             good_period;

   assign tol         = ERR_W'(lkd_pkg::tol_cycles(TOL_BASE, tol_code));
   assign need        = CNT_W'(lkd_pkg::qual_periods(QUAL_LOG2, QUAL_STEP, qual_code));
   assign good_inc    = {1'b0, good_q} + 1'b1;
   assign analyse     = eval && !(lock_q && !recheck);
   assign good_period = (err <= tol);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         good_q <= '0;
         lock_q <= 1'b0;
      end else if (analyse) begin
         if (good_period) begin
            if (good_q < need) good_q <= good_inc[CNT_W-1:0];
            if (good_inc >= {1'b0, need}) lock_q <= 1'b1;
         end else begin
            good_q <= '0;
            lock_q <= 1'b0;
         end
      end
   end

   assign lock = lock_q;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
   parameter int unsigned ERR_W     = 6,
   parameter int unsigned TOL_BASE  = 2,
   parameter int unsigned QUAL_LOG2 = 2,
   parameter int unsigned QUAL_STEP = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       synth_en,
   input  logic       retune,
   input  logic       prog_mode,
   input  logic       ref_tick,
   input  logic       pfd_up,
   input  logic       pfd_dn,
   input  logic [1:0] tol_code,
   input  logic [1:0] qual_code,
   input  logic       recheck,
   input  logic       pa_auto_off,
   output logic       lock,
   output logic       lock_pin,
   output logic       pa_en
);
   localparam int unsigned TOL_MAX = TOL_BASE << 3;

   generate
      if ((TOL_MAX + 1) >= (1 << ERR_W)) begin : g_bad_err_w
         $error("ERR_W too narrow to tell the largest tolerance from saturation");
      end
      if (TOL_BASE == 0 || QUAL_STEP == 0) begin : g_bad_codes
         $error("tolerance base and qualification step must be nonzero");
      end
   endgenerate

   logic             clr;
   logic [ERR_W-1:0] err;
   logic             armed;
   logic             lock_i;

   assign clr = !synth_en || retune;

   lkd_err_meter #(.ERR_W(ERR_W)) u_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .tick  (ref_tick),
      .up    (pfd_up),
      .dn    (pfd_dn),
      .err   (err),
      .armed (armed)
   );

   lkd_qualifier #(
      .ERR_W     (ERR_W),
      .TOL_BASE  (TOL_BASE),
      .QUAL_LOG2 (QUAL_LOG2),
      .QUAL_STEP (QUAL_STEP)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .eval      (ref_tick && armed),
      .err       (err),
      .tol_code  (tol_code),
      .qual_code (qual_code),
      .recheck   (recheck),
      .lock      (lock_i)
   );

   assign lock     = lock_i;
   assign lock_pin = lock_i && prog_mode;
   assign pa_en    = lock_i && !pa_auto_off;
endmodule

// File: rtl/lkd_checker.sv
module lkd_checker (
   input logic clk,
   input logic rst_n,
   input logic synth_en,
   input logic retune,
   input logic prog_mode,
   input logic ref_tick,
   input logic recheck,
   input logic pa_auto_off,
   input logic lock,
   input logic lock_pin,
   input logic pa_en
);
   AST_CLEAR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!synth_en || retune) |=> !lock); // R6

   AST_LOCK_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> $past(ref_tick)); // R2

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !recheck && synth_en && !retune) |=> lock); // R3

   AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock) |-> $past(!synth_en || retune || (recheck && ref_tick))); // R4

   AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_mode |-> !lock_pin); // R8

   AST_PA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      pa_en |-> (lock && !pa_auto_off)); // R7
endmodule

bind pll_lock_detect lkd_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .synth_en    (synth_en),
   .retune      (retune),
   .prog_mode   (prog_mode),
   .ref_tick    (ref_tick),
   .recheck     (recheck),
   .pa_auto_off (pa_auto_off),
   .lock        (lock),
   .lock_pin    (lock_pin),
   .pa_en       (pa_en)
);

// File: tb/tb_pll_lock_detect.sv
`timescale 1ns/1ps
module tb_pll_lock_detect;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic synth_en = 1'b1, retune = 1'b0, prog_mode = 1'b1;
   logic ref_tick = 1'b0, pfd_up = 1'b0, pfd_dn = 1'b0;
   logic [1:0] tol_code = 2'd0, qual_code = 2'd0;
   logic recheck = 1'b0, pa_auto_off = 1'b0;
   logic lock, lock_pin, pa_en;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   string cur_req = "R2";

   // Behavioural reference state
   int  m_err = 0, m_good = 0;
   bit  m_armed = 0, m_lock = 0;

   always #2 clk = ~clk;

   pll_lock_detect dut (
      .clk(clk), .rst_n(rst_n), .synth_en(synth_en), .retune(retune),
      .prog_mode(prog_mode), .ref_tick(ref_tick), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
      .tol_code(tol_code), .qual_code(qual_code), .recheck(recheck),
      .pa_auto_off(pa_auto_off), .lock(lock), .lock_pin(lock_pin), .pa_en(pa_en)
   );

   always @(posedge clk) begin
      int tol, need;
      cycles++;
      tol  = 2 * (1 << tol_code);
      need = 4 * (1 << (2 * qual_code));
      if (!rst_n || !synth_en || retune) begin
         m_err = 0; m_good = 0; m_armed = 0; m_lock = 0;
      end else if (ref_tick) begin
         if (m_armed && !(m_lock && !recheck)) begin
            if (m_err <= tol) begin
               if (m_good < need) m_good++;
               if (m_good >= need) m_lock = 1;
            end else begin
               m_good = 0; m_lock = 0;
            end
         end
         m_armed = 1;
         m_err = (pfd_up || pfd_dn) ? 1 : 0;
      end else if ((pfd_up || pfd_dn) && m_err < 63) begin
         m_err++;
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // Every-clock comparison against the reference model
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         check(cur_req, lock, m_lock);
         check("R8", lock_pin, m_lock && prog_mode);
         check("R7", pa_en, m_lock && !pa_auto_off);
      end
   end

   task automatic period(input int w, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         ref_tick = (i == 0);
         pfd_up   = (i < w) && (i % 2 == 0);
         pfd_dn   = (i < w) && (i % 2 == 1);
      end
   endtask

   task automatic periods(input int n, input int w);
      for (int k = 0; k < n; k++) period(w, 24);
   endtask

   task automatic clear_en;
      @(negedge clk);
      ref_tick = 0; pfd_up = 0; pfd_dn = 0;
      synth_en = 0;
      @(negedge clk);
      synth_en = 1;
   endtask

   task automatic probe(input string req, input logic exp);
      #1;
      check(req, lock, exp);
   endtask

   initial begin
      fork
         begin
            wait (cycles > 150000);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      #1;
      check("R2", lock, 1'b0);
      check("R7", pa_en, 1'b0);
      check("R8", lock_pin, 1'b0);
      @(negedge clk);
      rst_n = 1;

      // R1/R2: tolerance 2, qualification 4; width 2 is good
      cur_req = "R2";
      periods(4, 2);        probe("R2", 1'b0);
      periods(1, 2);        probe("R2", 1'b1);

      // R3: latch mode ignores bad periods
      cur_req = "R3";
      periods(3, 20);       probe("R3", 1'b1);

      // R6: retune clears
      cur_req = "R6";
      @(negedge clk); ref_tick = 0; pfd_up = 0; pfd_dn = 0; retune = 1;
      @(negedge clk); retune = 0;
      probe("R6", 1'b0);

      // R1: width 3 over tolerance 2 never locks; tolerance 4 accepts it
      cur_req = "R1";
      clear_en;
      periods(6, 3);        probe("R1", 1'b0);
      @(negedge clk); tol_code = 2'd1;
      clear_en;
      periods(5, 3);        probe("R1", 1'b1);

      // R5: bad period before lock resets the count (qualification 16)
      cur_req = "R5";
      tol_code = 2'd0; qual_code = 2'd1;
      clear_en;
      periods(11, 1); periods(1, 9); periods(16, 1);
      probe("R5", 1'b0);
      periods(1, 1);        probe("R5", 1'b1);

      // R4: re-check mode drops lock on a bad period
      cur_req = "R4";
      @(negedge clk); qual_code = 2'd0; recheck = 1;
      clear_en;
      periods(5, 0);        probe("R4", 1'b1);
      periods(1, 10);       probe("R4", 1'b1);
      periods(1, 0);        probe("R4", 1'b0);
      periods(3, 0);        probe("R4", 1'b0);
      periods(1, 0);        probe("R4", 1'b1);

      // R7 / R8 gating while locked
      @(negedge clk); pa_auto_off = 1; prog_mode = 0;
      #1; check("R7", pa_en, 1'b0); check("R8", lock_pin, 1'b0);
      @(negedge clk); pa_auto_off = 0; prog_mode = 1;
      #1; check("R7", pa_en, 1'b1); check("R8", lock_pin, 1'b1);

      // R6: synthesizer disable clears
      cur_req = "R6";
      clear_en;             probe("R6", 1'b0);

      // R1/R2 boundary: tolerance 16, qualification 256
      cur_req = "R2";
      @(negedge clk); recheck = 0; tol_code = 2'd3; qual_code = 2'd3;
      clear_en;
      periods(256, 16);     probe("R2", 1'b0);
      periods(1, 16);       probe("R2", 1'b1);
      cur_req = "R1";
      @(negedge clk); recheck = 1;
      periods(2, 17);       probe("R1", 1'b0);

      @(negedge clk); ref_tick = 0; pfd_up = 0; pfd_dn = 0;
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule